// File: doc/BRIEF.md
# LCD Scan Timing Generator

This block produces the line-by-line scan timing for a passive matrix LCD panel whose pixels come from a row-organised display RAM. It has two modes. In master mode it divides the system clock down to a line clock and drives that clock on a pin. It steps a line address through every common row of the panel and flips the frame polarity signal once per frame. It also drives a start pulse for the common driver during the last line of each frame.

Every line clock captures one full row of RAM read data into a segment latch. The RAM sits outside the block. Its read port is addressed by `row_addr` and its output is returned on `ram_row`. Nothing else competes for the address, so the scan never waits.

In slave mode the line clock, the frame polarity and the display-off request come in on pins from a master device. Each is passed through a multi-flop synchroniser before the block uses it. The start pulse driver is released and the pin output enables drop. Each frame polarity edge from the master sends the line address back to zero, which keeps the slave aligned to the master's frames. A display-off request from either source blanks the segment outputs. The scan keeps running while the display is off.

Top module: `lcd_scan_timer`

## Requirements
- R1: In master mode `cl_o` has a period of `CL_DIV` system clocks. It is high for the second half of each period. The line step (line clock event) happens on the same clock edge where `cl_o` falls.
- R2: `row_addr` starts at 0. It advances by one on each line clock event and wraps from `ROWS-1` back to 0.
- R3: On each line clock event the segment latch captures the `ram_row` value present on that edge, which is the data for the line being left. The captured value appears on `seg_o` after that edge.
- R4: In master mode `fr_o` inverts only on the line clock event where `row_addr` wraps from `ROWS-1` to 0. At all other times it holds its value.
- R5: In master mode `dyo_o` is high exactly while `row_addr` equals `ROWS-1`, so its pulse ends on the line clock edge where `fr_o` switches.
- R6: In master mode `pin_oe` and `dyo_oe` are 1, and `doff_o` follows `disp_off_req`.
- R7: In slave mode `pin_oe`, `dyo_oe` and `dyo_o` are 0. A falling edge on `cl_i` triggers a line clock event once it has passed through the synchroniser. `fr_o` follows the synchronised `fr_i`.
- R8: In slave mode any edge of the synchronised `fr_i` sets `row_addr` to 0, and this takes priority over a line clock event.
- R9: While display-off is active, `seg_o` is all zero. The source is `disp_off_req` in master mode and the synchronised `doff_i` in slave mode. `row_addr` and `fr_o` keep advancing meanwhile.
- R10: A synchronous reset (`rst` high) sets `row_addr`, `fr_o`, `dyo_o` and the segment latch to 0 and restarts the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| slave_mode | input | 1 | 0 selects master, 1 selects slave; held static outside reset |
| disp_off_req | input | 1 | Local display-off request, used in master mode |
| cl_i | input | 1 | Line clock from a master device (slave mode) |
| fr_i | input | 1 | Frame polarity from a master device (slave mode) |
| doff_i | input | 1 | Display-off from a master device (slave mode) |
| ram_row | input | COLS | Display RAM read data for `row_addr` |
| cl_o | output | 1 | Divided line clock for the pin (master mode) |
| fr_o | output | 1 | Frame polarity (AC drive) signal |
| doff_o | output | 1 | Display-off for the pin |
| pin_oe | output | 1 | Output enable for the line clock, polarity and display-off pins |
| dyo_o | output | 1 | Common start pulse |
| dyo_oe | output | 1 | Output enable for the start pulse pin |
| row_addr | output | clog2(ROWS) | Display RAM line address |
| seg_o | output | COLS | Latched segment data, blanked when display-off is active |

## Verification
The properties assume that `slave_mode` changes only while `rst` is high, and one property checks that assumption. They also assume that in slave mode each level on `cl_i` and `fr_i` lasts for more clocks than the synchroniser depth. The bench changes the mode only inside a reset pulse. It holds every slave pin level for four system clocks and drives all inputs on falling clock edges.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   // Width of an index able to address n items, never below one bit.
   function automatic int unsigned idx_w(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/lcd_pin_sync.sv
module lcd_pin_sync #(
   parameter int unsigned W      = 3,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/lcd_cl_source.sv
module lcd_cl_source #(
   parameter int unsigned CL_DIV      = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic slave_mode,
   input  logic disp_off_req,
   input  logic cl_i,
   input  logic fr_i,
   input  logic doff_i,
   output logic cl_o,
   output logic cl_en,
   output logic fr_edge,
   output logic fr_ext,
   output logic doff_eff
);
   localparam int unsigned CNT_W = lcd_scan_pkg::idx_w(CL_DIV);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CL_DIV - 1);
   localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(CL_DIV / 2);

   logic [CNT_W-1:0] div_cnt;
   logic             cl_s, fr_s, doff_s;
   logic             cl_prev, fr_prev;
   logic             master_tick, slave_tick;

   // Master divider, parked at zero while in slave mode.
   always_ff @(posedge clk) begin
      if (rst || slave_mode)      div_cnt <= '0;
      else if (div_cnt == CNT_LAST) div_cnt <= '0;
      else                          div_cnt <= div_cnt + 1'b1;
   end

   assign cl_o        = (div_cnt >= CNT_HALF);
   assign master_tick = !slave_mode && (div_cnt == CNT_LAST);

   // Slave pins: synchronise, then detect edges.
   lcd_pin_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   ({cl_i, fr_i, doff_i}),
      .q   ({cl_s, fr_s, doff_s})
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         cl_prev <= 1'b0;
         fr_prev <= 1'b0;
      end else begin
         cl_prev <= cl_s;
         fr_prev <= fr_s;
      end
   end

   assign slave_tick = slave_mode && cl_prev && !cl_s;
   assign fr_edge    = slave_mode && (fr_prev != fr_s);
   assign fr_ext     = fr_s;
   assign cl_en      = master_tick || slave_tick;
   assign doff_eff   = slave_mode ? doff_s : disp_off_req;
endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq #(
   parameter int unsigned ROWS = 33,
   localparam int unsigned ROW_W = lcd_scan_pkg::idx_w(ROWS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             slave_mode,
   input  logic             cl_en,
   input  logic             fr_edge,
   input  logic             fr_ext,
   output logic [ROW_W-1:0] row_addr,
   output logic             fr,
   output logic             dyo
);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

   logic [ROW_W-1:0] row_q;
   logic             fr_q;
   logic             at_last;

   assign at_last = (row_q == ROW_LAST);

   always_ff @(posedge clk) begin
      if (rst)          row_q <= '0;
      else if (fr_edge) row_q <= '0;
      else if (cl_en)   row_q <= at_last ? '0 : row_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)                                 fr_q <= 1'b0;
      else if (cl_en && at_last && !slave_mode) fr_q <= ~fr_q;
   end

   assign row_addr = row_q;
   assign fr       = slave_mode ? fr_ext : fr_q;
   assign dyo      = !slave_mode && at_last;
endmodule

// File: rtl/lcd_seg_latch.sv
module lcd_seg_latch #(
   parameter int unsigned COLS = 100
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cl_en,
   input  logic            blank,
   input  logic [COLS-1:0] row_data,
   output logic [COLS-1:0] seg
);
   logic [COLS-1:0] seg_q;

   always_ff @(posedge clk) begin
      if (rst)        seg_q <= '0;
      else if (cl_en) seg_q <= row_data;
   end

   assign seg = blank ? '0 : seg_q;
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer #(
   parameter int unsigned ROWS        = 33,
   parameter int unsigned COLS        = 100,
   parameter int unsigned CL_DIV      = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned ROW_W = lcd_scan_pkg::idx_w(ROWS)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             slave_mode,
   input  logic             disp_off_req,
   input  logic             cl_i,
   input  logic             fr_i,
   input  logic             doff_i,
   input  logic [COLS-1:0]  ram_row,
   output logic             cl_o,
   output logic             fr_o,
   output logic             doff_o,
   output logic             pin_oe,
   output logic             dyo_o,
   output logic             dyo_oe,
   output logic [ROW_W-1:0] row_addr,
   output logic [COLS-1:0]  seg_o
);
   generate
      if (CL_DIV < 2 || (CL_DIV % 2) != 0) begin : g_bad_div
         $error("CL_DIV must be even and at least 2");
      end
      if (ROWS < 2) begin : g_bad_rows
         $error("ROWS must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic cl_en, fr_edge, fr_ext, doff_eff;

   lcd_cl_source #(.CL_DIV(CL_DIV), .SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk          (clk),
      .rst          (rst),
      .slave_mode   (slave_mode),
      .disp_off_req (disp_off_req),
      .cl_i         (cl_i),
      .fr_i         (fr_i),
      .doff_i       (doff_i),
      .cl_o         (cl_o),
      .cl_en        (cl_en),
      .fr_edge      (fr_edge),
      .fr_ext       (fr_ext),
      .doff_eff     (doff_eff)
   );

   lcd_frame_seq #(.ROWS(ROWS)) u_seq (
      .clk        (clk),
      .rst        (rst),
      .slave_mode (slave_mode),
      .cl_en      (cl_en),
      .fr_edge    (fr_edge),
      .fr_ext     (fr_ext),
      .row_addr   (row_addr),
      .fr         (fr_o),
      .dyo        (dyo_o)
   );

   lcd_seg_latch #(.COLS(COLS)) u_seg (
      .clk      (clk),
      .rst      (rst),
      .cl_en    (cl_en),
      .blank    (doff_eff),
      .row_data (ram_row),
      .seg      (seg_o)
   );

   assign pin_oe = !slave_mode;
   assign dyo_oe = !slave_mode;
   assign doff_o = disp_off_req;
endmodule

// File: rtl/lcd_scan_timer_chk.sv
module lcd_scan_timer_chk #(
   parameter int unsigned ROWS = 33,
   parameter int unsigned COLS = 100,
   localparam int unsigned ROW_W = lcd_scan_pkg::idx_w(ROWS)
) (
   input logic             clk,
   input logic             rst,
   input logic             slave_mode,
   input logic             cl_en,
   input logic             doff_eff,
   input logic [ROW_W-1:0] row_addr,
   input logic             fr_o,
   input logic             dyo_o,
   input logic             dyo_oe,
   input logic             pin_oe,
   input logic [COLS-1:0]  seg_o
);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

   // Input assumption: the mode changes only under reset.
   a_env_mode_static: assert property (@(posedge clk) disable iff (rst)
      $stable(slave_mode));

   // R2
   a_r2_row_in_range: assert property (@(posedge clk) disable iff (rst)
      row_addr <= ROW_LAST);

   // R2
   a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
      (!slave_mode && cl_en) |=>
      row_addr == (($past(row_addr) == ROW_LAST) ? '0 : $past(row_addr) + 1'b1));

   // R2
   a_r2_row_hold: assert property (@(posedge clk) disable iff (rst)
      (!slave_mode && !cl_en) |=> $stable(row_addr));

   // R4
   a_r4_fr_hold: assert property (@(posedge clk) disable iff (rst)
      (!slave_mode && !(cl_en && row_addr == ROW_LAST)) |=> $stable(fr_o));

   // R5
   a_r5_dyo_before_fr: assert property (@(posedge clk) disable iff (rst)
      (!slave_mode && cl_en && dyo_o) |=> (fr_o != $past(fr_o)) && !dyo_o);

   // R6
   a_r6_master_oe: assert property (@(posedge clk) disable iff (rst)
      !slave_mode |-> (pin_oe && dyo_oe));

   // R7
   a_r7_slave_release: assert property (@(posedge clk) disable iff (rst)
      slave_mode |-> (!pin_oe && !dyo_oe && !dyo_o));

   // R9
   a_r9_blank: assert property (@(posedge clk) disable iff (rst)
      doff_eff |-> (seg_o == '0));
endmodule

bind lcd_scan_timer lcd_scan_timer_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .slave_mode (slave_mode),
   .cl_en      (cl_en),
   .doff_eff   (doff_eff),
   .row_addr   (row_addr),
   .fr_o       (fr_o),
   .dyo_o      (dyo_o),
   .dyo_oe     (dyo_oe),
   .pin_oe     (pin_oe),
   .seg_o      (seg_o)
);

// File: tb/tb_lcd_scan_timer.sv
module tb_lcd_scan_timer;
   localparam int ROWS   = 33;
   localparam int COLS   = 100;
   localparam int CL_DIV = 16;
   localparam int ROW_W  = 6;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             slave_mode = 1'b0;
   logic             disp_off_req = 1'b0;
   logic             cl_i = 1'b0;
   logic             fr_i = 1'b0;
   logic             doff_i = 1'b0;
   logic [COLS-1:0]  ram_row;
   logic             cl_o, fr_o, doff_o, pin_oe, dyo_o, dyo_oe;
   logic [ROW_W-1:0] row_addr;
   logic [COLS-1:0]  seg_o;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   // Bench model of the display RAM: a fixed pattern per line.
   function automatic logic [COLS-1:0] pat(input int r);
      logic [31:0] h;
      h = 32'h9E3779B9 * (r + 1);
      return {h, h, h, h[3:0]} ^ (100'd1 << (r + 50));
   endfunction

   assign ram_row = pat(int'(row_addr));

   lcd_scan_timer #(.ROWS(ROWS), .COLS(COLS), .CL_DIV(CL_DIV)) dut (
      .clk(clk), .rst(rst), .slave_mode(slave_mode), .disp_off_req(disp_off_req),
      .cl_i(cl_i), .fr_i(fr_i), .doff_i(doff_i), .ram_row(ram_row),
      .cl_o(cl_o), .fr_o(fr_o), .doff_o(doff_o), .pin_oe(pin_oe),
      .dyo_o(dyo_o), .dyo_oe(dyo_oe), .row_addr(row_addr), .seg_o(seg_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   // Wait for n falling edges of cl_o, sampling on falling clock edges.
   task automatic wait_cl(input int n);
      for (int i = 0; i < n; i++) begin
         logic p;
         p = cl_o;
         @(negedge clk);
         while (!(p === 1'b1 && cl_o === 1'b0)) begin
            p = cl_o;
            @(negedge clk);
         end
      end
   endtask

   task automatic do_reset(input logic mode);
      @(negedge clk);
      rst = 1'b1;
      slave_mode = mode;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic slave_pulse();
      cl_i = 1'b1;
      repeat (4) @(negedge clk);
      cl_i = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic int prev_row(input int r);
      return (r == 0) ? ROWS - 1 : r - 1;
   endfunction

   // Cumulative line clocks since reset, expected row, FR, DYO.
   localparam int NVEC = 7;
   localparam int VEC [NVEC][4] = '{
      '{1, 1, 0, 0}, '{2, 2, 0, 0}, '{31, 31, 0, 0}, '{32, 32, 0, 1},
      '{33, 0, 1, 0}, '{65, 32, 1, 1}, '{66, 0, 0, 0}
   };

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d expected=<100000", cycles);
            finish_run();
         end
      end
   end

   initial begin
      int done;
      int n;
      int r;
      repeat (3) @(negedge clk);
      rst = 1'b0;

      // R10: reset state, checked before the first active edge.
      check(row_addr == 0, "R10", "row after reset", 128'(row_addr), 0);
      check(fr_o == 0 && dyo_o == 0, "R10", "fr/dyo after reset", {fr_o, dyo_o}, 0);
      check(seg_o == '0, "R10", "seg after reset", 128'(seg_o), 0);
      check(pin_oe && dyo_oe, "R6", "master output enables", {pin_oe, dyo_oe}, 2'b11);

      // R1-table walk: R2, R3, R4, R5.
      done = 0;
      for (int v = 0; v < NVEC; v++) begin
         wait_cl(VEC[v][0] - done);
         done = VEC[v][0];
         check(int'(row_addr) == VEC[v][1], "R2", "row step", 128'(row_addr), 128'(VEC[v][1]));
         check(fr_o == VEC[v][2][0], "R4", "frame polarity", 128'(fr_o), 128'(VEC[v][2]));
         check(dyo_o == VEC[v][3][0], "R5", "start pulse", 128'(dyo_o), 128'(VEC[v][3]));
         check(seg_o == pat(prev_row(VEC[v][1])), "R3", "segment latch",
               128'(seg_o), 128'(pat(prev_row(VEC[v][1]))));
      end

      // R1: period and high phase of cl_o.
      n = 0;
      r = 0;
      begin
         logic p;
         p = cl_o;
         @(negedge clk);
         n = 1;
         if (cl_o) r++;
         while (!(p === 1'b1 && cl_o === 1'b0)) begin
            p = cl_o;
            @(negedge clk);
            n++;
            if (cl_o) r++;
         end
      end
      check(n == CL_DIV, "R1", "cl period", 128'(n), 128'(CL_DIV));
      check(r == CL_DIV / 2, "R1", "cl high phase", 128'(r), 128'(CL_DIV / 2));

      // R10: mid-run reset while FR is high.
      wait_cl(40);
      check(fr_o == 1, "R4", "fr high in odd frame", 128'(fr_o), 1);
      do_reset(1'b0);
      check(row_addr == 0 && fr_o == 0 && seg_o == '0 && dyo_o == 0, "R10",
            "mid-run reset", {fr_o, dyo_o, 6'(row_addr)}, 0);

      // R9 and R6: display off in master mode.
      wait_cl(3);
      disp_off_req = 1'b1;
      #1;
      check(seg_o == '0, "R9", "blank in master", 128'(seg_o), 0);
      check(doff_o == 1, "R6", "doff_o follows request", 128'(doff_o), 1);
      wait_cl(2);
      check(row_addr == 5, "R9", "row runs while blank", 128'(row_addr), 5);
      check(seg_o == '0, "R9", "still blank", 128'(seg_o), 0);
      @(negedge clk);
      disp_off_req = 1'b0;
      #1;
      check(seg_o == pat(4), "R9", "unblank shows latch", 128'(seg_o), 128'(pat(4)));
      check(doff_o == 0, "R6", "doff_o released", 128'(doff_o), 0);

      // Slave mode: R7, R8, R9.
      do_reset(1'b1);
      @(negedge clk);
      check(!pin_oe && !dyo_oe && !dyo_o, "R7", "slave releases pins",
            {pin_oe, dyo_oe, dyo_o}, 0);
      repeat (3) slave_pulse();
      check(row_addr == 3, "R7", "slave line step", 128'(row_addr), 3);
      check(seg_o == pat(2), "R3", "slave segment latch", 128'(seg_o), 128'(pat(2)));
      fr_i = 1'b1;
      repeat (4) @(negedge clk);
      check(fr_o == 1, "R7", "fr follows master", 128'(fr_o), 1);
      check(row_addr == 0, "R8", "fr edge restarts row", 128'(row_addr), 0);
      slave_pulse();
      check(row_addr == 1, "R8", "row resumes after fr edge", 128'(row_addr), 1);
      fr_i = 1'b0;
      repeat (4) @(negedge clk);
      check(row_addr == 0 && fr_o == 0, "R8", "falling fr edge restarts row",
            {fr_o, 6'(row_addr)}, 0);
      doff_i = 1'b1;
      repeat (4) @(negedge clk);
      check(seg_o == '0, "R9", "slave blank", 128'(seg_o), 0);
      slave_pulse();
      check(row_addr == 1 && dyo_o == 0, "R9", "slave row runs while blank",
            {dyo_o, 6'(row_addr)}, 1);
      doff_i = 1'b0;
      repeat (4) @(negedge clk);
      check(seg_o == pat(0), "R9", "slave unblank", 128'(seg_o), 128'(pat(0)));

      finish_run();
   end
endmodule